// File: doc/BRIEF.md
# Per-Trace Line Reference Scoreboard

This block counts how many in-flight instructions refer to each instruction cache line. It keeps one count for each pending speculative trace. The counts form a grid: each row is a cache line and each column is a trace. When an instruction issues, the count at its line and trace goes up by one. When it retires, that count goes down by one. If a trace's predicate resolves false, the whole column for that trace is zeroed in one cycle. The squashed instructions do not have to be unwound one at a time.

For every line the block reports whether its whole row is zero. The cache's replacement logic uses that flag as the only permission to evict the line. Issue at a full count and retire at an empty count are both refused, and each is reported as an error pulse. The cache itself, trace prediction and victim choice are outside this block.

Top module: `trace_ref_scoreboard`

## Requirements
- R1: While `rst_n` is low, every count is cleared. After reset, `line_free` is all ones and both error outputs are low.
- R2: An issue (`iss_vld` high) adds one to the count selected by `iss_line` (row) and `iss_trace` (column). Every other count is left unchanged.
- R3: A retire (`ret_vld` high) subtracts one from the count selected by `ret_line` and `ret_trace`.
- R4: Each bit t of `squash` that is high sets every count in column t to zero at the next clock edge. Several columns may be cleared in the same cycle, and the other columns keep their counts.
- R5: `line_free[i]` is 1 exactly when all counts in row i are zero. The flag reflects the counts as of the last clock edge, so it changes in the cycle after the event that moved the counts.
- R6: Counts are 4 bits wide and saturate at 15. An issue to a count already at 15 leaves it at 15 and makes `err_ovf` high for the one cycle after that edge.
- R7: If an issue and a retire address the same cell in the same cycle, that count does not change and no error is raised.
- R8: A retire to a count already at zero is ignored. It makes `err_udf` high for the one cycle after that edge.
- R9: A column clear overrides any issue or retire to the same column in the same cycle. The count ends at zero and no error is raised for that cell.
- R10: An issue and a retire that address different cells in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_vld | input | 1 | Issue event this cycle |
| iss_line | input | 6 | Cache line of the issuing instruction |
| iss_trace | input | 2 | Trace of the issuing instruction |
| ret_vld | input | 1 | Retire event this cycle |
| ret_line | input | 6 | Cache line of the retiring instruction |
| ret_trace | input | 2 | Trace of the retiring instruction |
| squash | input | 4 | One bit per trace; a high bit clears that column |
| line_free | output | 64 | Per-line flag: the row is all zero, so the line may be evicted |
| err_ovf | output | 1 | Pulse: an issue hit a saturated count on the previous edge |
| err_udf | output | 1 | Pulse: a retire hit a zero count on the previous edge |

## Verification
Every result of this block is due one clock edge after the stimulus. `line_free` follows the count registers with no further delay. Each error flag is a single register stage behind the edge that refused the update. The bench drives inputs at the falling edge and advances its own count grid at the rising edge. It then compares `line_free` and both error flags at the following falling edge, so every comparison lands exactly one edge after its cause. Count values are not visible at the ports, so they are inferred from how many retires it takes to free a line.

// File: rtl/trace_ref_scoreboard.sv
module trace_ref_scoreboard #(
  parameter int LINES  = 64,
  parameter int TRACES = 4,
  parameter int CW     = 4,
  parameter int LW     = $clog2(LINES),
  parameter int TW     = $clog2(TRACES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_vld,
  input  logic [LW-1:0]     iss_line,
  input  logic [TW-1:0]     iss_trace,
  input  logic              ret_vld,
  input  logic [LW-1:0]     ret_line,
  input  logic [TW-1:0]     ret_trace,
  input  logic [TRACES-1:0] squash,
  output logic [LINES-1:0]  line_free,
  output logic              err_ovf,
  output logic              err_udf
);
  localparam int CELLS = LINES * TRACES;

  logic [CELLS-1:0] ovf_hit, udf_hit;

  for (genvar r = 0; r < LINES; r++) begin : g_row
    logic [TRACES-1:0] empty;
    for (genvar t = 0; t < TRACES; t++) begin : g_col
      logic [CW-1:0] cnt;
      logic inc, dec, full, zero;
      assign inc  = iss_vld && iss_line == LW'(r) && iss_trace == TW'(t);
      assign dec  = ret_vld && ret_line == LW'(r) && ret_trace == TW'(t);
      assign full = &cnt;
      assign zero = ~|cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (squash[t])            cnt <= '0;
        else if (inc && !dec && !full) cnt <= cnt + 1'b1;
        else if (dec && !inc && !zero) cnt <= cnt - 1'b1;
      end

      assign ovf_hit[r*TRACES+t] = !squash[t] && inc && !dec && full;
      assign udf_hit[r*TRACES+t] = !squash[t] && dec && !inc && zero;
      assign empty[t] = zero;
    end
    assign line_free[r] = &empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ovf <= 1'b0;
      err_udf <= 1'b0;
    end else begin
      err_ovf <= |ovf_hit;
      err_udf <= |udf_hit;
    end
  end
endmodule

// File: rtl/trace_ref_scoreboard_chk.sv
module trace_ref_scoreboard_chk #(
  parameter int LINES  = 64,
  parameter int TRACES = 4,
  parameter int LW     = $clog2(LINES),
  parameter int TW     = $clog2(TRACES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_vld,
  input logic [LW-1:0]     iss_line,
  input logic [TW-1:0]     iss_trace,
  input logic              ret_vld,
  input logic [LW-1:0]     ret_line,
  input logic [TW-1:0]     ret_trace,
  input logic [TRACES-1:0] squash,
  input logic [LINES-1:0]  line_free,
  input logic              err_ovf,
  input logic              err_udf
);
  logic same_cell;
  assign same_cell = iss_vld && ret_vld && iss_line == ret_line && iss_trace == ret_trace;

  AST_ISSUE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !squash[iss_trace] && !same_cell) |=> !line_free[$past(iss_line)]); // R2
  AST_FULL_SQUASH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (&squash) |=> (&line_free)); // R4
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_vld && !ret_vld && squash == '0) |=> $stable(line_free)); // R5
  AST_OVF_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> $past(iss_vld)); // R6
  AST_SAME_CELL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    same_cell |=> (!err_ovf && !err_udf)); // R7
  AST_UDF_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    err_udf |-> $past(ret_vld)); // R8
  AST_SQUASH_BEATS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && squash[iss_trace]) |=> !err_ovf); // R9
endmodule

bind trace_ref_scoreboard trace_ref_scoreboard_chk #(.LINES(LINES), .TRACES(TRACES)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_line(iss_line), .iss_trace(iss_trace),
  .ret_vld(ret_vld), .ret_line(ret_line), .ret_trace(ret_trace), .squash(squash),
  .line_free(line_free), .err_ovf(err_ovf), .err_udf(err_udf)
);

// File: tb/trace_ref_scoreboard_tb_top.sv
module trace_ref_scoreboard_tb_top;
  localparam int LINES = 64;
  localparam int TRACES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_vld = 1'b0, ret_vld = 1'b0;
  logic [5:0] iss_line = '0, ret_line = '0;
  logic [1:0] iss_trace = '0, ret_trace = '0;
  logic [3:0] squash = '0;
  logic [63:0] line_free;
  logic err_ovf, err_udf;

  int n_chk = 0, n_fail = 0;
  int m [LINES][TRACES];
  logic x_ovf = 1'b0, x_udf = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  trace_ref_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_line(iss_line), .iss_trace(iss_trace),
    .ret_vld(ret_vld), .ret_line(ret_line), .ret_trace(ret_trace), .squash(squash),
    .line_free(line_free), .err_ovf(err_ovf), .err_udf(err_udf)
  );

  function automatic logic [63:0] exp_free();
    logic [63:0] f;
    for (int r = 0; r < LINES; r++) begin
      f[r] = 1'b1;
      for (int t = 0; t < TRACES; t++) if (m[r][t] != 0) f[r] = 1'b0;
    end
    return f;
  endfunction

  task automatic compare();
    logic [63:0] e;
    e = exp_free();
    n_chk += 3;
    if (line_free !== e) begin
      n_fail++;
      $display("FAIL %s line_free act %h exp %h", tag, line_free, e);
    end
    if (err_ovf !== x_ovf) begin
      n_fail++;
      $display("FAIL %s err_ovf act %b exp %b", tag, err_ovf, x_ovf);
    end
    if (err_udf !== x_udf) begin
      n_fail++;
      $display("FAIL %s err_udf act %b exp %b", tag, err_udf, x_udf);
    end
  endtask

  task automatic model_edge();
    x_ovf = 1'b0;
    x_udf = 1'b0;
    for (int r = 0; r < LINES; r++)
      for (int t = 0; t < TRACES; t++) begin
        bit up, dn;
        up = iss_vld && iss_line == r && iss_trace == t;
        dn = ret_vld && ret_line == r && ret_trace == t;
        if (squash[t]) m[r][t] = 0;
        else if (up && !dn) begin
          if (m[r][t] == 15) x_ovf = 1'b1; else m[r][t]++;
        end else if (dn && !up) begin
          if (m[r][t] == 0) x_udf = 1'b1; else m[r][t]--;
        end
      end
  endtask

  task automatic cyc(input bit iv, input int il, input int it,
                     input bit rv, input int rl, input int rt, input logic [3:0] sq);
    iss_vld = iv; iss_line = 6'(il); iss_trace = 2'(it);
    ret_vld = rv; ret_line = 6'(rl); ret_trace = 2'(rt);
    squash = sq;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 4'b0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < LINES; r++) for (int t = 0; t < TRACES; t++) m[r][t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();

    tag = "R2";
    repeat (3) cyc(1, 5, 1, 0, 0, 0, 4'b0);
    tag = "R3";
    repeat (2) cyc(0, 0, 0, 1, 5, 1, 4'b0);
    cyc(0, 0, 0, 1, 5, 1, 4'b0);

    tag = "R6";
    repeat (16) cyc(1, 9, 0, 0, 0, 0, 4'b0);
    idle();
    repeat (15) cyc(0, 0, 0, 1, 9, 0, 4'b0);

    tag = "R8";
    cyc(0, 0, 0, 1, 2, 3, 4'b0);
    idle();

    tag = "R7";
    cyc(1, 7, 2, 0, 0, 0, 4'b0);
    cyc(1, 7, 2, 1, 7, 2, 4'b0);
    cyc(1, 8, 2, 1, 8, 2, 4'b0);
    cyc(0, 0, 0, 1, 7, 2, 4'b0);

    tag = "R4";
    cyc(1, 10, 1, 0, 0, 0, 4'b0);
    cyc(1, 11, 2, 0, 0, 0, 4'b0);
    cyc(1, 12, 0, 0, 0, 0, 4'b0);
    cyc(1, 12, 1, 0, 0, 0, 4'b0);
    cyc(0, 0, 0, 0, 0, 0, 4'b0110);
    tag = "R9";
    for (int k = 0; k < 15; k++) cyc(1, 20, 3, 0, 0, 0, 4'b0);
    cyc(1, 20, 3, 0, 0, 0, 4'b1000);
    cyc(1, 21, 1, 1, 22, 1, 4'b0010);
    cyc(0, 0, 0, 1, 12, 0, 4'b0);

    tag = "R10";
    cyc(1, 30, 0, 0, 0, 0, 4'b0);
    cyc(1, 31, 1, 1, 30, 0, 4'b0);
    cyc(0, 0, 0, 1, 31, 1, 4'b0);

    tag = "R5";
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = $urandom_range(0, 99);
      cyc($urandom_range(0, 99) < 60, $urandom_range(0, 7), $urandom_range(0, 3),
          $urandom_range(0, 99) < 45, $urandom_range(0, 7), $urandom_range(0, 3),
          sel < 3 ? 4'($urandom_range(1, 15)) : 4'b0);
    end
    tag = "R4";
    cyc(0, 0, 0, 0, 0, 0, 4'b1111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule